// File: doc/BRIEF.md
# Serial Receiver with Threshold-Driven Request-to-Send

This block is the receive half of an asynchronous serial port. It watches the incoming serial line using a clock enable that pulses sixteen times per bit period. It assembles 8-bit characters, each framed by one start bit and one stop bit, and stores them in a 16-entry first-in first-out buffer. The host takes bytes out through a simple read strobe. The oldest byte is always visible on the read port, together with its framing-error flag.

An active-low request-to-send output tells the remote transmitter whether it may keep sending. In automatic mode this output is governed by a 2-bit threshold select. The three low thresholds (1, 4 and 8 bytes) release the request when the fill level reaches the threshold, and they re-assert it only after the host has emptied the buffer. The top threshold (14) works differently. It releases the request once a character is in progress with 15 bytes already stored and that character's first data bit has been sampled. It re-asserts the request as soon as any entry is free and no such character is underway. With automatic mode off, the output simply mirrors a software request bit.

Top module: `uart_rx_autorts`

## Requirements
- R1: After reset the buffer is empty (`fifo_count` = 0), `ovr_flag` is 0, and with `auto_rts_en` = 1 and `trig_sel` = 0 the output `rts_n` is 0.
- R2: A character is received LSB first. A low level on `rxd` is confirmed as a start bit on the 8th enable pulse after it is first seen. Each data bit and the stop bit are then sampled every 16 enable pulses. The byte is appended to the buffer and `rd_data` shows the oldest stored byte.
- R3: A low pulse on `rxd` that is shorter than 8 enable pulses stores nothing, and a full character that follows it is received intact.
- R4: A low level at the stop-bit sample stores the byte with `rd_ferr` = 1. A high level there stores it with `rd_ferr` = 0.
- R5: The buffer holds 16 bytes in arrival order. `rd_en` pops one byte per cycle, and `rd_en` has no effect while the buffer is empty.
- R6: A character that completes while 16 bytes are stored is dropped, and `ovr_flag` becomes 1. The flag stays 1 through reads until `ovr_clr` is pulsed.
- R7: `trig_sel` encodes the threshold as 0→1, 1→4, 2→8 and 3→14. With `auto_rts_en` = 1 and `trig_sel` in 0..2, `rts_n` goes to 1 in the cycle the fill level reaches the threshold.
- R8: With `trig_sel` in 0..2, once `rts_n` is 1 it stays 1 until the fill level is 0, and then it returns to 0.
- R9: With `trig_sel` = 3 and 15 bytes stored, `rts_n` stays 0 through the start bit of an incoming character. It goes to 1 once that character's first data bit has been sampled, and it is 1 whenever 16 bytes are stored.
- R10: With `trig_sel` = 3, `rts_n` is 0 whenever at most 15 bytes are stored and no character is past its first data bit while 15 are stored.
- R11: Characters that arrive while `rts_n` is 1 are still stored as long as the buffer has a free entry.
- R12: With `auto_rts_en` = 0, `rts_n` equals the inverse of `sw_rts_req`, whatever the fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Enable pulsing 16 times per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| rd_en | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest stored byte |
| rd_ferr | output | 1 | Framing-error flag of the oldest byte |
| fifo_count | output | 5 | Number of stored bytes (0..16) |
| trig_sel | input | 2 | Threshold select: 0→1, 1→4, 2→8, 3→14 |
| auto_rts_en | input | 1 | Enables automatic request-to-send |
| sw_rts_req | input | 1 | Software request used when automatic mode is off |
| ovr_clr | input | 1 | Clears the overrun flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
The assertions take for granted that `trig_sel` and `auto_rts_en` hold steady while bytes are stored. The held low-threshold state is only meaningful for the threshold in force when it was set, so the stimulus changes these settings only while the buffer is empty. The assertions also assume the host never pops and the receiver never completes a character in the same cycle in a way that moves the fill level by more than one. Because a completed character is stored one cycle after its stop-bit sample, the bench issues reads only during idle gaps between characters, never close to a stop-bit sample. Serial stimulus is driven in whole bit periods, with the enable pulsing every other clock.

// File: rtl/uart_rx_autorts.sv
module uart_rx_autorts #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int OW   = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rxd,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          rd_ferr,
  output logic [CW-1:0] fifo_count,
  input  logic [1:0]    trig_sel,
  input  logic          auto_rts_en,
  input  logic          sw_rts_req,
  input  logic          ovr_clr,
  output logic          ovr_flag,
  output logic          rts_n
);
  localparam logic [OW-1:0] MID  = OW'(OSR/2 - 1);
  localparam logic [OW-1:0] LAST = OW'(OSR - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_t;

  rx_state_t       st;
  logic [OW-1:0]   os_cnt;
  logic [3:0]      bit_idx;
  logic [7:0]      shreg;
  logic            push_req, fe_bit;
  logic [8:0]      mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   lvl;
  logic            lo_hold, lo_stop, hi_stop, past_bit0;

  wire full  = (cnt == CW'(DEPTH));
  wire empty = (cnt == '0);
  wire push  = push_req && !full;
  wire pop   = rd_en && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; os_cnt <= '0; bit_idx <= '0; shreg <= '0;
      push_req <= 1'b0; fe_bit <= 1'b0;
    end else begin
      push_req <= 1'b0;
      if (os_tick) begin
        case (st)
          S_IDLE: if (!rxd) begin st <= S_START; os_cnt <= '0; end
          S_START:
            if (os_cnt == MID) begin
              os_cnt <= '0; bit_idx <= '0;
              st <= rxd ? S_IDLE : S_DATA;
            end else os_cnt <= os_cnt + 1'b1;
          S_DATA:
            if (os_cnt == LAST) begin
              os_cnt  <= '0;
              shreg   <= {rxd, shreg[7:1]};
              bit_idx <= bit_idx + 1'b1;
              if (bit_idx == 4'd7) st <= S_STOP;
            end else os_cnt <= os_cnt + 1'b1;
          default:
            if (os_cnt == LAST) begin
              os_cnt <= '0; st <= S_IDLE;
              push_req <= 1'b1; fe_bit <= !rxd;
            end else os_cnt <= os_cnt + 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) if (push) mem[wp] <= {fe_bit, shreg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; ovr_flag <= 1'b0; lo_hold <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push_req && full) ovr_flag <= 1'b1;
      else if (ovr_clr)     ovr_flag <= 1'b0;
      lo_hold <= lo_stop;
    end
  end

  always_comb begin
    case (trig_sel)
      2'd0:    lvl = CW'(1);
      2'd1:    lvl = CW'(4);
      2'd2:    lvl = CW'(8);
      default: lvl = CW'(DEPTH - 2);
    endcase
  end

  assign past_bit0 = (st == S_DATA && bit_idx != '0) || st == S_STOP || push_req;
  assign lo_stop   = (cnt >= lvl) || (lo_hold && !empty);
  assign hi_stop   = full || (cnt == CW'(DEPTH - 1) && past_bit0);
  assign rts_n     = auto_rts_en ? ((trig_sel == 2'd3) ? hi_stop : lo_stop) : !sw_rts_req;

  assign rd_data    = mem[rp][7:0];
  assign rd_ferr    = mem[rp][8];
  assign fifo_count = cnt;
endmodule

module uart_rx_autorts_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          auto_rts_en,
  input logic          sw_rts_req,
  input logic [1:0]    trig_sel,
  input logic [CW-1:0] fifo_count,
  input logic          rts_n,
  input logic          ovr_flag,
  input logic          ovr_clr
);
  // R5
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == $past(fifo_count)) || (fifo_count == $past(fifo_count) + 1'b1)
    || (fifo_count == $past(fifo_count) - 1'b1));

  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && !ovr_clr |=> ovr_flag);

  // R7
  trig1_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_rts_en && trig_sel == 2'd0 && fifo_count != '0 |-> rts_n);

  // R8
  empty_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_rts_en && trig_sel != 2'd3 && fifo_count == '0 |-> !rts_n);

  // R9
  full_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_rts_en && fifo_count == CW'(DEPTH) |-> rts_n);

  // R10
  hi_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_rts_en && trig_sel == 2'd3 && fifo_count <= CW'(DEPTH - 2) |-> !rts_n);

  // R12
  sw_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |-> rts_n != sw_rts_req);
endmodule

bind uart_rx_autorts uart_rx_autorts_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .sw_rts_req(sw_rts_req),
  .trig_sel(trig_sel), .fifo_count(fifo_count), .rts_n(rts_n),
  .ovr_flag(ovr_flag), .ovr_clr(ovr_clr)
);

// File: tb/test_uart_rx_autorts.sv
module test_uart_rx_autorts;
  logic       clk = 0, rst_n = 0, os_tick = 0, rxd = 1, rd_en = 0;
  logic [1:0] trig_sel = 0;
  logic       auto_rts_en = 1, sw_rts_req = 0, ovr_clr = 0;
  logic [7:0] rd_data;
  logic       rd_ferr, ovr_flag, rts_n;
  logic [4:0] fifo_count;
  int checks = 0, fails = 0;
  logic done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) os_tick <= ~os_tick;

  uart_rx_autorts i_uart_rx_autorts (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .rd_en(rd_en),
    .rd_data(rd_data), .rd_ferr(rd_ferr), .fifo_count(fifo_count),
    .trig_sel(trig_sel), .auto_rts_en(auto_rts_en), .sw_rts_req(sw_rts_req),
    .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .rts_n(rts_n)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] val(int t, int k);
    return 8'((k * 37 + t * 59 + 5) & 255);
  endfunction

  function automatic int level(int t);
    return (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
  endfunction

  task automatic drive_bit(logic v);
    @(posedge clk) rxd <= v;
    repeat (31) @(posedge clk);
  endtask

  task automatic send(logic [7:0] b, logic stop);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit(stop);
    drive_bit(1'b1);
    drive_bit(1'b1);
    @(negedge clk);
  endtask

  task automatic pop();
    @(posedge clk) rd_en <= 1;
    @(posedge clk) rd_en <= 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n <= 1;
    @(negedge clk);
    check("R1 count", fifo_count, 0);
    check("R1 ovr", ovr_flag, 0);
    check("R1 rts_n", rts_n, 0);

    // R5: read on empty ignored; R3: short low pulse ignored
    pop();
    check("R5 empty pop", fifo_count, 0);
    @(posedge clk) rxd <= 0;
    repeat (11) @(posedge clk);
    @(posedge clk) rxd <= 1;
    repeat (80) @(posedge clk);
    @(negedge clk);
    check("R3 glitch count", fifo_count, 0);
    send(8'h81, 1'b1);
    check("R3 count after glitch", fifo_count, 1);
    check("R2 data", rd_data, 8'h81);
    pop();
    check("R5 count after pop", fifo_count, 0);

    // R4: framing flag stored with byte; R12 with non-empty buffer
    auto_rts_en <= 0;
    send(8'hA5, 1'b0);
    send(8'h3C, 1'b1);
    check("R4 count", fifo_count, 2);
    sw_rts_req <= 1; @(negedge clk);
    check("R12 sw=1", rts_n, 0);
    sw_rts_req <= 0; @(negedge clk);
    check("R12 sw=0", rts_n, 1);
    check("R4 data0", rd_data, 8'hA5);
    check("R4 ferr0", rd_ferr, 1);
    pop();
    check("R4 data1", rd_data, 8'h3C);
    check("R4 ferr1", rd_ferr, 0);
    pop();
    auto_rts_en <= 1;

    // R7 R8 R11 R5 R2: sweep low thresholds, fill and drain
    for (int t = 0; t < 3; t++) begin
      trig_sel <= 2'(t);
      @(negedge clk);
      check("R8 empty start", rts_n, 0);
      for (int k = 1; k <= 16; k++) begin
        send(val(t, k), 1'b1);
        check("R11 stored", fifo_count, k);
        check("R7 rts_n", rts_n, (k >= level(t)) ? 1 : 0);
      end
      for (int k = 1; k <= 16; k++) begin
        check("R2 order", rd_data, val(t, k));
        check("R4 clean", rd_ferr, 0);
        pop();
        check("R5 count", fifo_count, 16 - k);
        check("R8 rts_n", rts_n, (k < 16) ? 1 : 0);
      end
    end

    // R9 R10 R6: top threshold
    trig_sel <= 2'd3;
    for (int k = 1; k <= 15; k++) begin
      send(val(3, k), 1'b1);
      check("R10 rts_n", rts_n, 0);
    end
    begin
      logic [7:0] b;
      b = val(3, 16);
      drive_bit(1'b0);
      @(negedge clk);
      check("R9 start bit", rts_n, 0);
      drive_bit(b[0]);
      @(negedge clk);
      check("R9 after bit0", rts_n, 1);
      for (int i = 1; i < 8; i++) drive_bit(b[i]);
      drive_bit(1'b1);
      drive_bit(1'b1);
      drive_bit(1'b1);
      @(negedge clk);
    end
    check("R9 full count", fifo_count, 16);
    check("R9 full rts_n", rts_n, 1);
    send(8'hEE, 1'b1);
    check("R6 dropped", fifo_count, 16);
    check("R6 ovr", ovr_flag, 1);
    check("R6 head", rd_data, val(3, 1));
    pop();
    check("R10 room", rts_n, 0);
    check("R6 sticky", ovr_flag, 1);
    @(posedge clk) ovr_clr <= 1;
    @(posedge clk) ovr_clr <= 0;
    @(negedge clk);
    check("R6 cleared", ovr_flag, 0);
    for (int k = 2; k <= 16; k++) begin
      check("R6 order", rd_data, val(3, k));
      pop();
    end
    check("R6 drained", fifo_count, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule